// File: doc/BRIEF.md
# Display Layer FIFO Refill Request Controller

This block decides when the pixel FIFO of one display layer asks the memory interconnect for a read burst. It watches the FIFO fill level together with the words already requested but not yet written back. It works by hysteresis. While idle it waits until the level falls to a programmable low mark. It then issues burst requests until the level plus in-flight data reaches a programmable high mark, and after that it goes quiet again. A request is made only when the FIFO has room for a whole burst on top of everything already in flight, so the FIFO cannot overflow.

A merge flag pools three layer FIFOs into one, which triples the capacity the block accounts against. In that mode software writes the thresholds at three times their normal values, and the block uses them as written. The block also picks the frame base address for the current field. It chooses between an even-field and an odd-field base from a field-ID input and a polarity bit. Address stepping, the bus protocol and the pixel datapath belong to neighbouring blocks.

Top module: `vfwm_ctrl`

## Requirements
- R1: While `rst_n` is low, at every clock edge `rd_req` is 0, `out_cnt` is cleared to 0 and `base_addr` is cleared to 0.
- R2: An idle controller enters the refill state only on the clock edge after a cycle in which the layer was enabled and `fifo_level` was at or below the low threshold. A fresh refill episode therefore starts only from a level at or below the low mark.
- R3: `rd_req` is never 1 while `fifo_level` plus the requested-but-unreturned words is at or above the effective high threshold. Once that sum reaches the high threshold, the controller returns to idle.
- R4: `rd_req` is 1 only if `fifo_level` plus the unreturned words plus `burst_len` is at most the effective capacity. A FIFO that drains and is filled only by returned beats therefore never holds more than the capacity.
- R5: The effective capacity is CAP_WORDS when `merge_en` is 0 and 3*CAP_WORDS when `merge_en` is 1.
- R6: When the programmed high threshold is not above the low threshold, or is above the effective capacity, the effective high threshold equals the effective capacity.
- R7: The low threshold is read from `thr_cfg[11:0]` and the high threshold from `thr_cfg[27:16]`. Bits [15:12] and [31:28] have no effect.
- R8: `out_cnt` rises by one for each cycle with `rd_req` and `req_ack` both 1. It falls by one when the `burst_len`-th `wr_beat` of the oldest burst arrives. It never exceeds OUT_MAX, and `rd_req` stays 0 while it equals OUT_MAX.
- R9: While `layer_en` is 0, `rd_req` is 0. One edge later `out_cnt` and the unreturned-word count are 0, and the controller is idle.
- R10: One edge after any cycle, `base_addr` equals `base_odd` if `field_id` XOR `field_pol` was 1 in that cycle, and `base_even` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| layer_en | input | 1 | Layer enable; 0 holds requests off and clears credit |
| merge_en | input | 1 | 1 = three FIFOs pooled, capacity tripled |
| thr_cfg | input | 32 | Threshold word: low in [11:0], high in [27:16] |
| burst_len | input | BURST_W | Words per burst, nonzero, stable while data is in flight |
| fifo_level | input | LVL_W | Words currently held in the FIFO |
| req_ack | input | 1 | Interconnect accepts the current request |
| wr_beat | input | 1 | One returned word written into the FIFO this cycle |
| field_id | input | 1 | Current field identifier |
| field_pol | input | 1 | Field identifier polarity |
| base_even | input | ADDR_W | Even-field frame base |
| base_odd | input | ADDR_W | Odd-field frame base |
| rd_req | output | 1 | Burst read request, held until acknowledged |
| out_cnt | output | CNT_W | Bursts requested and not yet fully returned |
| base_addr | output | ADDR_W | Selected field base, registered |

## Verification
The hardest case to reach is a request that is blocked only by in-flight data. This happens when the level alone would allow a burst, but the level plus unreturned words leaves no room below the high mark or below the capacity. Another case is the outstanding limit stalling requests while the FIFO is still under the low mark. The bench reaches both by pairing a slow write-back (one beat every other cycle) with fast drain rates and withheld acknowledges. It does this across merged and unmerged capacities, several burst lengths and degenerate threshold pairs. In every cycle it compares the request and the outstanding count against an arithmetic model of the FIFO.

// File: rtl/vfwm_pkg.sv
// Package: shared constants and types for the FIFO refill request controller.
// Assumes thresholds are packed into one 32-bit configuration word.
package vfwm_pkg;
    localparam int THR_W  = 12;   // width of each threshold field
    localparam int LO_LSB = 0;    // low threshold field position
    localparam int HI_LSB = 16;   // high threshold field position
    localparam int POOL_WAYS = 3; // FIFOs pooled in merged mode

    typedef enum logic {
        WM_IDLE = 1'b0,
        WM_FILL = 1'b1
    } wm_state_e;
endpackage

// File: rtl/vfwm_thr_decode.sv
// Module: vfwm_thr_decode
// Extracts the thresholds from the configuration word and derives the
// effective capacity and high mark. Assumes thresholds are already scaled
// by software for merged mode; only the capacity depends on merge_en.
module vfwm_thr_decode
    import vfwm_pkg::*;
#(
    parameter int CAP_WORDS = 1024,
    parameter int SUM_W     = 14
) (
    input  logic [31:0]      thr_cfg,
    input  logic             merge_en,
    output logic [SUM_W-1:0] low_thr,
    output logic [SUM_W-1:0] high_eff,
    output logic [SUM_W-1:0] cap_eff
);
    localparam logic [SUM_W-1:0] CAP_ONE  = SUM_W'(CAP_WORDS);
    localparam logic [SUM_W-1:0] CAP_POOL = SUM_W'(POOL_WAYS * CAP_WORDS);

    logic [SUM_W-1:0] hi_raw;

    // Field extraction and zero extension to the accounting width.
    always_comb begin
        low_thr = SUM_W'(thr_cfg[LO_LSB +: THR_W]);
        hi_raw  = SUM_W'(thr_cfg[HI_LSB +: THR_W]);
    end

    // Capacity selection by pooling mode.
    always_comb begin
        cap_eff = merge_en ? CAP_POOL : CAP_ONE;
    end

    // Degenerate or out-of-range high mark falls back to full capacity.
    always_comb begin
        if ((hi_raw <= low_thr) || (hi_raw > cap_eff)) begin
            high_eff = cap_eff;
        end else begin
            high_eff = hi_raw;
        end
    end
endmodule

// File: rtl/vfwm_credit.sv
// Module: vfwm_credit
// Tracks words requested but not yet written back, and the number of
// outstanding bursts. Assumes bursts return in order, one word per wr_beat,
// and burst_len stays fixed while any burst is outstanding.
module vfwm_credit #(
    parameter int SUM_W   = 14,
    parameter int BURST_W = 6,
    parameter int CNT_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               layer_en,
    input  logic               take,
    input  logic               wr_beat,
    input  logic [BURST_W-1:0] burst_len,
    output logic [SUM_W-1:0]   pend_words,
    output logic [CNT_W-1:0]   out_cnt,
    output logic               burst_done
);
    logic [BURST_W-1:0] beat_q;
    logic [SUM_W-1:0]   add_w;
    logic [SUM_W-1:0]   sub_w;

    // Detect the last returned word of the oldest burst.
    always_comb begin
        burst_done = layer_en && wr_beat && (beat_q == (burst_len - 1'b1));
        add_w      = take    ? SUM_W'(burst_len) : '0;
        sub_w      = wr_beat ? SUM_W'(1)         : '0;
    end

    // Unreturned-word accounting.
    always_ff @(posedge clk) begin
        if (!rst_n || !layer_en) begin
            pend_words <= '0;
        end else begin
            pend_words <= pend_words + add_w - sub_w;
        end
    end

    // Beat position within the burst currently being written back.
    always_ff @(posedge clk) begin
        if (!rst_n || !layer_en) begin
            beat_q <= '0;
        end else if (burst_done) begin
            beat_q <= '0;
        end else if (wr_beat) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // Outstanding-burst counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !layer_en) begin
            out_cnt <= '0;
        end else begin
            case ({take, burst_done})
                2'b10:   out_cnt <= out_cnt + 1'b1;
                2'b01:   out_cnt <= out_cnt - 1'b1;
                default: out_cnt <= out_cnt;
            endcase
        end
    end
endmodule

// File: rtl/vfwm_hyst.sv
// Module: vfwm_hyst
// Hysteresis state machine plus request admission. Starts refilling at the
// low mark, stops when level plus in-flight words reaches the high mark,
// and admits a burst only if it fits in the capacity and a slot is free.
module vfwm_hyst
    import vfwm_pkg::*;
#(
    parameter int LVL_W   = 12,
    parameter int SUM_W   = 14,
    parameter int BURST_W = 6,
    parameter int CNT_W   = 3,
    parameter int OUT_MAX = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               layer_en,
    input  logic [LVL_W-1:0]   fifo_level,
    input  logic [SUM_W-1:0]   pend_words,
    input  logic [BURST_W-1:0] burst_len,
    input  logic [SUM_W-1:0]   low_thr,
    input  logic [SUM_W-1:0]   high_eff,
    input  logic [SUM_W-1:0]   cap_eff,
    input  logic [CNT_W-1:0]   out_cnt,
    output logic               rd_req,
    output logic               filling
);
    wm_state_e        state_q;
    wm_state_e        state_d;
    logic [SUM_W-1:0] lvl_ext;
    logic [SUM_W-1:0] fill_sum;
    logic [SUM_W-1:0] fill_post;
    logic             room_ok;
    logic             below_hi;
    logic             slot_ok;

    // Effective fill: present words plus words already on their way.
    always_comb begin
        lvl_ext   = SUM_W'(fifo_level);
        fill_sum  = lvl_ext + pend_words;
        fill_post = fill_sum + SUM_W'(burst_len);
    end

    // Admission conditions for one more burst.
    always_comb begin
        room_ok  = (fill_post <= cap_eff);
        below_hi = (fill_sum < high_eff);
        slot_ok  = (out_cnt < CNT_W'(OUT_MAX));
    end

    // Next-state choice between idle and refill.
    always_comb begin
        state_d = state_q;
        if (!layer_en) begin
            state_d = WM_IDLE;
        end else if ((state_q == WM_IDLE) && (lvl_ext <= low_thr)) begin
            state_d = WM_FILL;
        end else if ((state_q == WM_FILL) && !below_hi) begin
            state_d = WM_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request strobe, held while admission holds.
    always_comb begin
        filling = (state_q == WM_FILL);
        rd_req  = layer_en && filling && room_ok && below_hi && slot_ok;
    end
endmodule

// File: rtl/vfwm_field_base.sv
// Module: vfwm_field_base
// Selects the even- or odd-field frame base from field ID and polarity.
// PIPE=1 registers the result (reset to zero); PIPE=0 passes it through.
module vfwm_field_base #(
    parameter int ADDR_W = 32,
    parameter bit PIPE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_id,
    input  logic              field_pol,
    input  logic [ADDR_W-1:0] base_even,
    input  logic [ADDR_W-1:0] base_odd,
    output logic [ADDR_W-1:0] base_addr
);
    logic [ADDR_W-1:0] pick;

    // Field parity decides which base applies.
    always_comb begin
        pick = (field_id ^ field_pol) ? base_odd : base_even;
    end

    generate
        if (PIPE) begin : g_reg
            // Registered base output.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_addr <= '0;
                end else begin
                    base_addr <= pick;
                end
            end
        end else begin : g_comb
            // Unregistered base output.
            always_comb begin
                base_addr = rst_n ? pick : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/vfwm_ctrl.sv
// Module: vfwm_ctrl (top)
// FIFO watermark burst request controller for one display layer.
// Assumes one returned word per wr_beat, in-order burst return, and a
// nonzero burst_len that is held while bursts are outstanding.
module vfwm_ctrl
    import vfwm_pkg::*;
#(
    parameter int CAP_WORDS = 1024,
    parameter int BURST_W   = 6,
    parameter int OUT_MAX   = 4,
    parameter int ADDR_W    = 32,
    parameter int LVL_W     = $clog2(POOL_WAYS * CAP_WORDS + 1),
    parameter int CNT_W     = $clog2(OUT_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               layer_en,
    input  logic               merge_en,
    input  logic [31:0]        thr_cfg,
    input  logic [BURST_W-1:0] burst_len,
    input  logic [LVL_W-1:0]   fifo_level,
    input  logic               req_ack,
    input  logic               wr_beat,
    input  logic               field_id,
    input  logic               field_pol,
    input  logic [ADDR_W-1:0]  base_even,
    input  logic [ADDR_W-1:0]  base_odd,
    output logic               rd_req,
    output logic [CNT_W-1:0]   out_cnt,
    output logic [ADDR_W-1:0]  base_addr
);
    localparam int WIDE  = (LVL_W > THR_W) ? LVL_W : THR_W;
    localparam int SUM_W = WIDE + 2;

    logic [SUM_W-1:0] low_thr;
    logic [SUM_W-1:0] high_eff;
    logic [SUM_W-1:0] cap_eff;
    logic [SUM_W-1:0] pend_words;
    logic             burst_done;
    logic             filling;
    logic             take;

    // Accepted request handshake.
    always_comb begin
        take = rd_req && req_ack;
    end

    vfwm_thr_decode #(
        .CAP_WORDS (CAP_WORDS),
        .SUM_W     (SUM_W)
    ) u_thr (
        .thr_cfg  (thr_cfg),
        .merge_en (merge_en),
        .low_thr  (low_thr),
        .high_eff (high_eff),
        .cap_eff  (cap_eff)
    );

    vfwm_credit #(
        .SUM_W   (SUM_W),
        .BURST_W (BURST_W),
        .CNT_W   (CNT_W)
    ) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .layer_en   (layer_en),
        .take       (take),
        .wr_beat    (wr_beat),
        .burst_len  (burst_len),
        .pend_words (pend_words),
        .out_cnt    (out_cnt),
        .burst_done (burst_done)
    );

    vfwm_hyst #(
        .LVL_W   (LVL_W),
        .SUM_W   (SUM_W),
        .BURST_W (BURST_W),
        .CNT_W   (CNT_W),
        .OUT_MAX (OUT_MAX)
    ) u_hyst (
        .clk        (clk),
        .rst_n      (rst_n),
        .layer_en   (layer_en),
        .fifo_level (fifo_level),
        .pend_words (pend_words),
        .burst_len  (burst_len),
        .low_thr    (low_thr),
        .high_eff   (high_eff),
        .cap_eff    (cap_eff),
        .out_cnt    (out_cnt),
        .rd_req     (rd_req),
        .filling    (filling)
    );

    vfwm_field_base #(
        .ADDR_W (ADDR_W),
        .PIPE   (1'b1)
    ) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .field_id  (field_id),
        .field_pol (field_pol),
        .base_even (base_even),
        .base_odd  (base_odd),
        .base_addr (base_addr)
    );
endmodule

// File: rtl/vfwm_ctrl_chk.sv
// Module: vfwm_ctrl_chk
// Property checker for vfwm_ctrl, attached by bind. Assumes the registered
// base-address variant.
module vfwm_ctrl_chk #(
    parameter int LVL_W   = 12,
    parameter int SUM_W   = 14,
    parameter int BURST_W = 6,
    parameter int CNT_W   = 3,
    parameter int OUT_MAX = 4,
    parameter int ADDR_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               layer_en,
    input logic               req_ack,
    input logic               rd_req,
    input logic               filling,
    input logic               burst_done,
    input logic [LVL_W-1:0]   fifo_level,
    input logic [SUM_W-1:0]   pend_words,
    input logic [BURST_W-1:0] burst_len,
    input logic [SUM_W-1:0]   low_thr,
    input logic [SUM_W-1:0]   high_eff,
    input logic [SUM_W-1:0]   cap_eff,
    input logic [CNT_W-1:0]   out_cnt,
    input logic               field_id,
    input logic               field_pol,
    input logic [ADDR_W-1:0]  base_even,
    input logic [ADDR_W-1:0]  base_odd,
    input logic [ADDR_W-1:0]  base_addr
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (out_cnt == '0) && (base_addr == '0)); // R1

    AST_START_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filling) |-> (SUM_W'($past(fifo_level)) <= $past(low_thr))); // R2

    AST_BELOW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ((SUM_W'(fifo_level) + pend_words) < high_eff)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ((SUM_W'(fifo_level) + pend_words + SUM_W'(burst_len)) <= cap_eff)); // R4

    AST_OUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= CNT_W'(OUT_MAX)); // R8

    AST_OUT_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (layer_en && rd_req && req_ack && !burst_done) |=> (out_cnt == $past(out_cnt) + 1'b1)); // R8

    AST_DIS_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
        !layer_en |-> !rd_req); // R9

    AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !layer_en |=> (out_cnt == '0) && (pend_words == '0)); // R9

    AST_FIELD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (base_addr == (($past(field_id) ^ $past(field_pol)) ? $past(base_odd) : $past(base_even)))); // R10
endmodule

bind vfwm_ctrl vfwm_ctrl_chk #(
    .LVL_W   (LVL_W),
    .SUM_W   (SUM_W),
    .BURST_W (BURST_W),
    .CNT_W   (CNT_W),
    .OUT_MAX (OUT_MAX),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .layer_en   (layer_en),
    .req_ack    (req_ack),
    .rd_req     (rd_req),
    .filling    (filling),
    .burst_done (burst_done),
    .fifo_level (fifo_level),
    .pend_words (pend_words),
    .burst_len  (burst_len),
    .low_thr    (low_thr),
    .high_eff   (high_eff),
    .cap_eff    (cap_eff),
    .out_cnt    (out_cnt),
    .field_id   (field_id),
    .field_pol  (field_pol),
    .base_even  (base_even),
    .base_odd   (base_odd),
    .base_addr  (base_addr)
);

// File: tb/sim_vfwm_ctrl.sv
`timescale 1ns/1ps
// Bench: sweeps pooling mode, threshold pairs, burst lengths and drain rates
// against an arithmetic FIFO model; checks every cycle.
module sim_vfwm_ctrl;
    localparam int CAP     = 64;
    localparam int BURST_W = 5;
    localparam int OUT_MAX = 3;
    localparam int ADDR_W  = 16;
    localparam int LVL_W   = $clog2(3 * CAP + 1);
    localparam int CNT_W   = $clog2(OUT_MAX + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               layer_en = 1'b0;
    logic               merge_en = 1'b0;
    logic [31:0]        thr_cfg = '0;
    logic [BURST_W-1:0] burst_len = 5'd4;
    logic [LVL_W-1:0]   fifo_level = '0;
    logic               req_ack = 1'b0;
    logic               wr_beat = 1'b0;
    logic               field_id = 1'b0;
    logic               field_pol = 1'b0;
    logic [ADDR_W-1:0]  base_even = '0;
    logic [ADDR_W-1:0]  base_odd = '0;
    logic               rd_req;
    logic [CNT_W-1:0]   out_cnt;
    logic [ADDR_W-1:0]  base_addr;

    int total = 0;
    int fails = 0;
    int lvl, pend, ocnt, beat, st, cyc, maxlvl;
    int cap, lo, hi, bl;
    bit en_v;

    always #4 clk = ~clk;

    vfwm_ctrl #(
        .CAP_WORDS (CAP),
        .BURST_W   (BURST_W),
        .OUT_MAX   (OUT_MAX),
        .ADDR_W    (ADDR_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .layer_en(layer_en), .merge_en(merge_en),
        .thr_cfg(thr_cfg), .burst_len(burst_len), .fifo_level(fifo_level),
        .req_ack(req_ack), .wr_beat(wr_beat), .field_id(field_id),
        .field_pol(field_pol), .base_even(base_even), .base_odd(base_odd),
        .rd_req(rd_req), .out_cnt(out_cnt), .base_addr(base_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: check registered state, drive inputs, check request, update model.
    task automatic step(input int div);
        bit exp_req, wr, ack;
        int sum;
        @(negedge clk);
        chk(out_cnt == CNT_W'(ocnt), "R8 R9 out_cnt", int'(out_cnt), ocnt);
        layer_en   = en_v;
        fifo_level = LVL_W'(lvl);
        wr = en_v && (pend > 0) && (cyc % 2 == 0);
        wr_beat = wr;
        #1;
        sum = lvl + pend;
        exp_req = en_v && (st != 0) && (sum + bl <= cap) && (sum < hi) && (ocnt < OUT_MAX);
        chk(rd_req == exp_req, "R2 R3 R4 rd_req", int'(rd_req), int'(exp_req));
        if (!en_v) chk(rd_req == 1'b0, "R9 disabled rd_req", int'(rd_req), 0);
        if (rd_req) begin
            chk(sum < hi, "R3 sum below high", sum, hi);
            chk(sum + bl <= cap, "R4 burst fits", sum + bl, cap);
        end
        ack = rd_req && (cyc % 4 != 3);
        req_ack = ack;
        if (!en_v) st = 0;
        else if (st == 0 && lvl <= lo) st = 1;
        else if (st == 1 && sum >= hi) st = 0;
        if (ack && en_v) begin pend += bl; ocnt++; end
        if (wr) begin
            pend--; lvl++; beat++;
            if (beat == bl) begin beat = 0; ocnt--; end
        end
        if (lvl > 0 && (cyc % div == 0)) lvl--;
        if (lvl > maxlvl) maxlvl = lvl;
        if (!en_v) begin pend = 0; ocnt = 0; beat = 0; end
        chk(lvl <= cap, "R4 no overflow", lvl, cap);
        cyc++;
    endtask

    task automatic run_cfg(input bit m, input int lo_v, input int hi_v, input int bl_v, input int div);
        en_v = 1'b0;
        step(div);
        merge_en  = m;
        thr_cfg   = {4'hA, 12'(hi_v), 4'h5, 12'(lo_v)};  // R7 stray bits set
        burst_len = BURST_W'(bl_v);
        cap = m ? 3 * CAP : CAP;
        lo  = lo_v;
        hi  = (hi_v <= lo_v || hi_v > cap) ? cap : hi_v;  // R6
        bl  = bl_v;
        lvl = cap / 2;
        maxlvl = 0;
        step(div);
        en_v = 1'b1;
        for (int i = 0; i < 300; i++) begin
            if (i == 150) en_v = 1'b0;
            if (i == 152) en_v = 1'b1;
            step(div);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        lvl = 0; pend = 0; ocnt = 0; beat = 0; st = 0; cyc = 0; maxlvl = 0;
        cap = CAP; lo = 0; hi = CAP; bl = 4; en_v = 1'b0;
        base_even = 16'h1234; base_odd = 16'hABCD;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_req == 1'b0, "R1 rd_req in reset", int'(rd_req), 0);
        chk(out_cnt == '0, "R1 out_cnt in reset", int'(out_cnt), 0);
        chk(base_addr == '0, "R1 base_addr in reset", int'(base_addr), 0);
        rst_n = 1'b1;
        // R10: all four field/polarity combinations
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            field_id  = k[0];
            field_pol = k[1];
            base_even = ADDR_W'(16'h1000 + k);
            base_odd  = ADDR_W'(16'h8000 + k);
            @(negedge clk);
            chk(base_addr == ((k[0] ^ k[1]) ? ADDR_W'(16'h8000 + k) : ADDR_W'(16'h1000 + k)),
                "R10 field base", int'(base_addr),
                (k[0] ^ k[1]) ? 16'h8000 + k : 16'h1000 + k);
        end
        for (int m = 0; m < 2; m++) begin
            for (int t = 0; t < 3; t++) begin
                for (int b = 0; b < 2; b++) begin
                    for (int d = 1; d <= 3; d++) begin
                        int lo_v, hi_v;
                        case (t)
                            0: begin lo_v = m ? 48 : 16; hi_v = m ? 150 : 50; end
                            1: begin lo_v = 20; hi_v = 10; end      // R6 high below low
                            default: begin lo_v = 24; hi_v = 4000; end // R6 high above capacity
                        endcase
                        run_cfg(m[0], lo_v, hi_v, b ? 8 : 4, d);
                        if (m == 1 && t == 0 && d == 1)
                            chk(maxlvl > CAP, "R5 pooled capacity used", maxlvl, CAP + 1);
                    end
                end
            end
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule